// File: doc/BRIEF.md
# Nibble-Immediate 8-bit RISC Core

This block is a small single-issue processor core with separate instruction and data memories. Each clock cycle it fetches one 8-bit instruction from the address on its instruction port, decodes it and retires it in the same cycle. It works on four 8-bit general registers, a program counter and a one-bit equality flag. Constants are assembled in r3 four bits at a time. Jump targets always come from a register. A conditional jump tests only the equality flag.

Both memories sit outside the core and are read combinationally: the instruction byte and the data-read byte must be valid in the same cycle as the address. A single level-sensitive interrupt line makes the core fetch its handler address from a fixed data-memory slot. A dedicated return instruction resumes the interrupted program.

Top module: `nib8_core`

## Requirements
- R1: Reset clears the PC, every register and the flag, and enables interrupts. The first fetch after reset is at address 0.
- R2: Instruction bits [7:4] are the opcode, bits [3:2] pick rd and bits [1:0] pick rs. Opcode 0 copies rs into rd.
- R3: Opcodes 1 to 5 write rd with, in order: rd+rs mod 256, rd-rs mod 256, rd AND rs, rd OR rs, and the bitwise inverse of rs.
- R4: Opcodes 6, 7 and 8 shift rd by the amount in rs: left logical, right logical and right arithmetic. An amount of 8 or more gives 0 for the logical shifts and sign fill for the arithmetic shift.
- R5: Opcode 9 sets the flag to 1 when rd equals rs and to 0 otherwise, and writes no register. Opcode 10 with bits [3:2]=00 loads the PC from rs when the flag is 1, and otherwise steps to PC+1.
- R6: Opcode 11 with bits [3:2]=00 loads the PC from rs unconditionally.
- R7: Opcode 12 puts bits [3:0] into r3[7:4] and opcode 13 puts them into r3[3:0]. In both cases the other nibble of r3 is kept.
- R8: Opcode 14 loads rd from data memory at the address in rs. Opcode 15 writes rd to data memory at the address in rs. The write strobe rises only for opcode 15.
- R9: When the interrupt line is high and interrupts are enabled, the fetched instruction is discarded. The PC of that instruction is saved as the return address, and the PC is loaded from data address 250.
- R10: Once an interrupt is taken, further interrupts are masked. The byte 0xB4 reloads the PC from the return address and unmasks them.
- R11: Every instruction that does not transfer control moves the PC on by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, level sensitive |
| imem_addr | output | 8 | Instruction fetch address (the PC) |
| imem_data | input | 8 | Instruction byte at imem_addr |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 8 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 8 | Data memory byte at dmem_addr |

## Verification
The ALU opcodes are swept over every pair of a ten-value operand set. The set holds zero, one, the sign boundary 0x7F/0x80, all-ones, and the shift amounts 7, 8 and 9. These values separate wrap-around from saturation, logical from arithmetic fill, and in-range from oversize shift amounts. Compare-and-branch runs with equal and unequal pairs, so a taken branch and a fall-through branch store different markers. Immediate loads are tried with both nibble orders to show that the untouched half survives. The interrupt run holds the request high through the whole handler, which tells masking apart from re-entry, and then raises it again after the return to show that interrupts are enabled again.

// File: rtl/nib8_pkg.sv
package nib8_pkg;
   typedef enum logic [3:0] {
      OP_MOV  = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_AND  = 4'd3,
      OP_OR   = 4'd4,  OP_NOT  = 4'd5,  OP_SLL  = 4'd6,  OP_SRL  = 4'd7,
      OP_SRA  = 4'd8,  OP_CMP  = 4'd9,  OP_JEQ  = 4'd10, OP_JMP  = 4'd11,
      OP_LIHI = 4'd12, OP_LILO = 4'd13, OP_LD   = 4'd14, OP_ST   = 4'd15
   } op_e;

   localparam logic [7:0] RET_WORD = 8'hB4;
endpackage

// File: rtl/nib8_alu.sv
module nib8_alu
   import nib8_pkg::*;
#(
   parameter int DW = 8
) (
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);
   localparam int SW = $clog2(DW);

   if (DW < 2) begin : g_bad_width
      $error("nib8_alu: DW must be at least 2");
   end

   logic          big_shift;
   logic [SW-1:0] sh;

   assign sh        = b[SW-1:0];
   assign big_shift = (b >= DW[DW-1:0]);

   always_comb begin
      unique case (op)
         OP_MOV:  y = b;
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_NOT:  y = ~b;
         OP_SLL:  y = big_shift ? '0 : (a << sh);
         OP_SRL:  y = big_shift ? '0 : (a >> sh);
         OP_SRA:  y = big_shift ? {DW{a[DW-1]}} : DW'($signed(a) >>> sh);
         default: y = b;
      endcase
   end
endmodule

// File: rtl/nib8_regs.sv
module nib8_regs #(
   parameter int DW   = 8,
   parameter int NREG = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(NREG)-1:0] ra,
   input  logic [$clog2(NREG)-1:0] rb,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] wa,
   input  logic [DW-1:0]           wd,
   output logic [DW-1:0]           qa,
   output logic [DW-1:0]           qb
);
   logic [DW-1:0] bank [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank[i] <= '0;
         else if (we && (wa == i))
            bank[i] <= wd;
      end
   end

   assign qa = bank[ra];
   assign qb = bank[rb];
endmodule

// File: rtl/nib8_core.sv
module nib8_core
   import nib8_pkg::*;
#(
   parameter int DW       = 8,
   parameter int AW       = 8,
   parameter int NREG     = 4,
   parameter int VEC_ADDR = 250
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq,
   output logic [AW-1:0] imem_addr,
   input  logic [7:0]    imem_data,
   output logic [AW-1:0] dmem_addr,
   output logic [DW-1:0] dmem_wdata,
   output logic          dmem_we,
   input  logic [DW-1:0] dmem_rdata
);
   localparam int RIW = $clog2(NREG);
   localparam int IMM = 4;
   localparam logic [RIW-1:0] IMM_REG = RIW'(NREG - 1);

   if (NREG != 4) begin : g_bad_nreg
      $error("nib8_core: the 2-bit register fields need NREG == 4");
   end
   if (AW != DW) begin : g_bad_aw
      $error("nib8_core: jump targets come from registers, so AW must equal DW");
   end
   if (DW != 2 * IMM) begin : g_bad_dw
      $error("nib8_core: two nibble loads must fill a register");
   end

   logic [AW-1:0]  pc, pc_nxt, ret_addr, ret_nxt;
   logic           flag, flag_nxt, int_en, int_en_nxt;
   op_e            op;
   logic [RIW-1:0] rd_i, rs_i, ra_sel, wa;
   logic [DW-1:0]  rd_val, rs_val, alu_y, wd;
   logic           wen, take;

   assign op   = op_e'(imem_data[7:4]);
   assign rd_i = imem_data[3:2];
   assign rs_i = imem_data[1:0];
   assign take = irq && int_en;
   assign ra_sel = (op == OP_LIHI || op == OP_LILO) ? IMM_REG : rd_i;

   nib8_regs #(.DW(DW), .NREG(NREG)) u_regs (
      .clk(clk), .rst_n(rst_n), .ra(ra_sel), .rb(rs_i),
      .we(wen), .wa(wa), .wd(wd), .qa(rd_val), .qb(rs_val)
   );

   nib8_alu #(.DW(DW)) u_alu (
      .op(op), .a(rd_val), .b(rs_val), .y(alu_y)
   );

   always_comb begin
      pc_nxt     = pc + 1'b1;
      ret_nxt    = ret_addr;
      flag_nxt   = flag;
      int_en_nxt = int_en;
      wen        = 1'b0;
      wa         = rd_i;
      wd         = alu_y;
      dmem_addr  = rs_val;
      dmem_wdata = rd_val;
      dmem_we    = 1'b0;
      if (take) begin
         dmem_addr  = AW'(VEC_ADDR);
         pc_nxt     = dmem_rdata;
         ret_nxt    = pc;
         int_en_nxt = 1'b0;
      end else begin
         unique case (op)
            OP_CMP: flag_nxt = (rd_val == rs_val);
            OP_JEQ: if (imem_data[3:2] == 2'b00 && flag) pc_nxt = rs_val;
            OP_JMP: begin
               if (imem_data == RET_WORD) begin
                  pc_nxt     = ret_addr;
                  int_en_nxt = 1'b1;
               end else if (imem_data[3:2] == 2'b00) begin
                  pc_nxt = rs_val;
               end
            end
            OP_LIHI: begin
               wen = 1'b1;
               wa  = IMM_REG;
               wd  = {imem_data[IMM-1:0], rd_val[IMM-1:0]};
            end
            OP_LILO: begin
               wen = 1'b1;
               wa  = IMM_REG;
               wd  = {rd_val[DW-1:IMM], imem_data[IMM-1:0]};
            end
            OP_LD: begin
               wen = 1'b1;
               wd  = dmem_rdata;
            end
            OP_ST:   dmem_we = 1'b1;
            default: wen = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc       <= '0;
         ret_addr <= '0;
         flag     <= 1'b0;
         int_en   <= 1'b1;
      end else begin
         pc       <= pc_nxt;
         ret_addr <= ret_nxt;
         flag     <= flag_nxt;
         int_en   <= int_en_nxt;
      end
   end

   assign imem_addr = pc;
endmodule

// File: rtl/nib8_core_chk.sv
module nib8_core_chk #(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq,
   input logic [AW-1:0] imem_addr,
   input logic [7:0]    imem_data,
   input logic          dmem_we,
   input logic [DW-1:0] dmem_rdata,
   input logic          int_en,
   input logic [DW-1:0] rs_val
);
   logic taking;
   assign taking = irq && int_en;

   // R9: a taken interrupt fetches next from the vector byte
   p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
      taking |=> imem_addr == $past(dmem_rdata));

   // R10: a taken interrupt masks further ones
   p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      taking |=> !int_en);

   // R10: the return byte re-enables interrupts
   p_unmask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!taking && imem_data == 8'hB4) |=> int_en);

   // R8: the store strobe comes only from opcode 15 and never during a take
   p_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> (imem_data[7:4] == 4'hF && !taking));

   // R6: an unconditional jump lands on the rs value
   p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!taking && imem_data[7:2] == 6'b101100) |=> imem_addr == $past(rs_val));

   // R11: straight-line opcodes step the PC by one
   p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!taking && (imem_data[7:4] <= 4'd9 || imem_data[7:4] >= 4'd12))
      |=> imem_addr == AW'($past(imem_addr) + 1'b1));
endmodule

bind nib8_core nib8_core_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .imem_addr(imem_addr),
   .imem_data(imem_data), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
   .int_en(int_en), .rs_val(rs_val)
);

// File: tb/nib8_core_bench.sv
module nib8_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       irq = 1'b0;
   logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic       dmem_we;
   logic [7:0] imem [256];
   logic [7:0] dmem [256];
   int         total = 0, bad = 0, cycles = 0, stores = 0, cur = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   assign imem_data  = imem[imem_addr];
   assign dmem_rdata = dmem[dmem_addr];

   always @(posedge clk) begin
      if (dmem_we) begin
         dmem[dmem_addr] <= dmem_wdata;
         stores++;
      end
   end

   nib8_core u_nib8_core (
      .clk(clk), .rst_n(rst_n), .irq(irq), .imem_addr(imem_addr),
      .imem_data(imem_data), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
      .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
   );

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear();
      for (int i = 0; i < 256; i++) begin imem[i] = 8'h00; dmem[i] = 8'h00; end
      cur = 0;
   endtask
   task automatic emit(logic [7:0] b); imem[cur[7:0]] = b; cur++; endtask
   task automatic li(logic [7:0] v);
      emit({4'hC, v[7:4]}); emit({4'hD, v[3:0]});
   endtask
   // r2 <- r3 after loading v, then store r2 to addr
   task automatic put(logic [7:0] v, logic [7:0] addr);
      li(v); emit(8'h0B); li(addr); emit(8'hFB);
   endtask
   task automatic halt();
      logic [7:0] here;
      here = 8'(cur + 2); li(here); emit(8'hB3);
   endtask
   task automatic run(int n);
      rst_n = 1'b0; stores = 0;
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [7:0] ref_alu(int op, logic [7:0] a, logic [7:0] b);
      case (op)
         0: return b;
         1: return 8'((a + b) % 256);
         2: return 8'((256 + a - b) % 256);
         3: return a & b;
         4: return a | b;
         5: return 8'hFF ^ b;
         6: return (b >= 8) ? 8'h00 : 8'((a * (1 << b)) % 256);
         7: return (b >= 8) ? 8'h00 : 8'(a / (1 << b));
         default: return (b >= 8) ? {8{a[7]}} :
            8'((a / (1 << b)) | (a[7] ? (8'hFF << (8 - b)) : 8'h00));
      endcase
   endfunction

   logic [7:0] vals [10] = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h08,
                             8'h09, 8'h7F, 8'h80, 8'hFE, 8'hFF};

   initial begin
      clear();
      #1 chk("R1 fetch address in reset", imem_addr, 8'h00);

      // R1: flag clear (je r3 must fall through), registers zero; R11 stepping
      clear();
      emit(8'hA3);
      for (int i = 0; i < 4; i++) dmem[8'h40 + i] = 8'hEE;
      li(8'h40); emit(8'hF3);
      li(8'h41); emit(8'hF7);
      li(8'h42); emit(8'hFB);
      run(12);
      chk("R1 r0 cleared", dmem[8'h40], 8'h00);
      chk("R1 r1 cleared", dmem[8'h41], 8'h00);
      chk("R1 r2 cleared", dmem[8'h42], 8'h00);
      chk("R11 pc after 12 steps", imem_addr, 8'd12);

      // R2 R3 R4: opcode sweep, r0 = a, r1 = b, op r0,r1
      for (int op = 0; op < 9; op++)
         for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++) begin
               clear();
               li(vals[i]); emit(8'h03);
               li(vals[j]); emit(8'h07);
               emit({4'(op), 4'b0001});
               emit(8'h08);
               li(8'h40); emit(8'hFB);
               halt();
               run(16);
               total++;
               if (dmem[8'h40] !== ref_alu(op, vals[i], vals[j])) begin
                  bad++;
                  $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     op == 0 ? "R2" : (op < 6 ? "R3" : "R4"), op, vals[i],
                     vals[j], dmem[8'h40], ref_alu(op, vals[i], vals[j]));
               end
               if (op == 3 && i == 9 && j == 9)
                  chk("R8 one store strobe per program", 8'(stores), 8'd1);
            end

      // R5: compare then conditional jump
      for (int k = 0; k < 4; k++) begin
         logic [7:0] a, b;
         a = (k < 2) ? 8'h5A : 8'h80;
         b = (k[0]) ? a : 8'(a ^ 8'h01);
         clear();
         li(a); emit(8'h03); li(b); emit(8'h07);
         emit(8'h91);
         li(8'h60); emit(8'hA3);
         put(8'h11, 8'h40); halt();
         cur = 8'h60;
         put(8'h22, 8'h40); halt();
         run(30);
         chk("R5 cmp/je", dmem[8'h40], (a == b) ? 8'h22 : 8'h11);
      end

      // R6: unconditional jump
      clear();
      li(8'h70); emit(8'hB3);
      put(8'h44, 8'h40); halt();
      cur = 8'h70;
      put(8'h33, 8'h40); halt();
      run(20);
      chk("R6 jmp taken", dmem[8'h40], 8'h33);

      // R7: nibble loads keep the other half
      clear();
      li(8'hA5); emit(8'hC3); emit(8'h0B); li(8'h40); emit(8'hFB);
      li(8'hA5); emit(8'hDC); emit(8'h0B); li(8'h41); emit(8'hFB);
      halt();
      run(20);
      chk("R7 high nibble load", dmem[8'h40], 8'h35);
      chk("R7 low nibble load", dmem[8'h41], 8'hAC);

      // R8: load through rs
      clear();
      dmem[8'h30] = 8'h9C;
      li(8'h30); emit(8'hE7); emit(8'h09); li(8'h40); emit(8'hFB);
      halt();
      run(14);
      chk("R8 load", dmem[8'h40], 8'h9C);

      // R9 R10: interrupt entry, masking, return, re-enable
      clear();
      dmem[250] = 8'h80;
      cur = 8'h80;
      put(8'h55, 8'h41);
      emit(8'hB4);
      run(5);
      irq = 1'b1;
      @(posedge clk); #1;
      chk("R9 vector fetch", imem_addr, 8'h80);
      repeat (6) @(posedge clk);
      #1;
      chk("R10 masked in handler", imem_addr, 8'h86);
      irq = 1'b0;
      @(posedge clk); #1;
      chk("R10 return address", imem_addr, 8'h05);
      chk("R9 handler ran", dmem[8'h41], 8'h55);
      irq = 1'b1;
      @(posedge clk); #1;
      chk("R10 re-enabled", imem_addr, 8'h80);
      irq = 1'b0;

      done = 1;
      summary();
   end
endmodule